// File: doc/BRIEF.md
# Parallel I/O port with grouped pulldown control

This block is an eight-pin general purpose I/O port sitting on a simple synchronous CPU bus. Software sets the direction of each pin, loads an output data latch, and reads back the pin levels. Each pin drives three pad control lines: the output value, the output enable and a weak pulldown enable.

The pulldowns are controlled in groups of four pins by a write-only register whose bits are active-low, so that after reset every pulldown is on. A pin that is configured as an output never has its pulldown enabled. A global option input, tied off at chip level, can inhibit every pulldown at once. Pad inputs pass through a two-flop synchronizer before they can be read.

The bus decode is a small enumerated selector with four named values: `SEL_NONE` (unmapped address), `SEL_DATA` (data register), `SEL_DIR` (direction register) and `SEL_PDN` (pulldown register). Each bus cycle resolves to exactly one of them, and there is no sequential state beyond the registers themselves.

Top module: `gpio_pd_port`

## Requirements
- R1: The direction register is read/write at address 0x06. Bit i set to 1 drives `pad_oe[i]` high, and bit i cleared to 0 drives it low. A write takes effect on the clock edge that samples `bus_wr`.
- R2: After reset the direction, data and pulldown registers are all zero. This gives `pad_oe` = 0x00, `pad_out` = 0x00, `pad_pd_en` = 0xFF (with `pd_inhibit` low), and `bus_rdata` = 0x00.
- R3: Whenever `pad_oe[i]` is 1, `pad_pd_en[i]` is 0, regardless of the pulldown register.
- R4: The pulldown register at address 0x10 uses write data bit 1 for pins 7..4 and bit 0 for pins 3..0. Both bits are active-low: 0 enables the pulldown on input pins of that group, and 1 disables it.
- R5: The pulldown register is write-only. A read of address 0x10 returns 0x00.
- R6: While `pd_inhibit` is high, `pad_pd_en` is 0x00. The input acts combinationally and has no register in its path.
- R7: The data register at address 0x02 drives `pad_out` from the clock edge that samples the write, whatever the pin direction.
- R8: A read of 0x02 returns, for each bit, the data latch when that pin is an output and the synchronized pad input when it is an input. A pad change can be read only after it has been sampled by two clock edges.
- R9: `bus_rdata` is registered. It updates on the edge that samples `bus_rd` and is 0x00 after any edge without a read. Reads of unmapped addresses return 0x00.
- R10: Writes to unmapped addresses change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Asynchronous pad input levels |
| pd_inhibit | input | 1 | Global pulldown inhibit option |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pd_en | output | 8 | Pad pulldown enables |

## Verification
The assertions assume that a strobe is held for one clock cycle, and that `bus_addr` and `bus_wdata` are stable while it is sampled. They also assume that `pd_inhibit` is a static option, although the logic is combinational and tolerates changes. The stimulus follows these rules by driving every bus input at the falling edge and raising each strobe for exactly one cycle. It never asserts `bus_wr` and `bus_rd` together, and it moves `pad_in` only at falling edges so that the synchronizer latency can be counted exactly.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_DATA = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 8'h06;
    localparam logic [ADDR_W-1:0] ADDR_PDN  = 8'h10;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_PDN
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_DATA)     return SEL_DATA;
        else if (a == ADDR_DIR) return SEL_DIR;
        else if (a == ADDR_PDN) return SEL_PDN;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4,
    localparam int NGROUP = WIDTH / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  pad_sync,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [NGROUP-1:0] pdn_q
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] rd_mux;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pdn_q  <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_DATA: data_q <= bus_wdata;
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_PDN:  pdn_q  <= bus_wdata[NGROUP-1:0];
                SEL_NONE: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_mux = (dir_q & data_q) | (~dir_q & pad_sync);
            SEL_DIR:  rd_mux = dir_q;
            SEL_PDN:  rd_mux = '0;
            SEL_NONE: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dir_q == '0 && data_q == '0 && pdn_q == '0));

    assert_pdn_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_PDN) |=> bus_rdata == '0);

    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

    assert_unmapped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(data_q) && $stable(pdn_q)));

endmodule

// File: rtl/gpio_pd_padctl.sv
module gpio_pd_padctl #(
    parameter int WIDTH   = 8,
    parameter int GROUP_W = 4,
    localparam int NGROUP = WIDTH / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [NGROUP-1:0] pdn_q,
    input  logic              pd_inhibit,
    output logic [WIDTH-1:0]  pad_pd_en
);

    genvar p;
    generate
        for (p = 0; p < WIDTH; p++) begin : g_pin
            localparam int GRP = p / GROUP_W;
            assign pad_pd_en[p] = !pd_inhibit && !dir_q[p] && !pdn_q[GRP];
        end
    endgenerate

    genvar g;
    generate
        for (g = 0; g < NGROUP; g++) begin : g_grp_chk
            assert_group_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
                pdn_q[g] |-> pad_pd_en[g*GROUP_W +: GROUP_W] == '0);
            assert_group_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!pdn_q[g] && !pd_inhibit) |->
                    pad_pd_en[g*GROUP_W +: GROUP_W] == ~dir_q[g*GROUP_W +: GROUP_W]);
        end
    endgenerate

    assert_inhibit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pd_inhibit |-> pad_pd_en == '0);

endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int GROUP_W     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int NGROUP     = WIDTH / GROUP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic              pd_inhibit,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pd_en
);

    logic [WIDTH-1:0]  pad_sync;
    logic [WIDTH-1:0]  data_q;
    logic [WIDTH-1:0]  dir_q;
    logic [NGROUP-1:0] pdn_q;

    gpio_pd_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_pd_regs #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .pad_sync  (pad_sync),
        .bus_rdata (bus_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pdn_q     (pdn_q)
    );

    gpio_pd_padctl #(.WIDTH(WIDTH), .GROUP_W(GROUP_W)) padctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_q      (dir_q),
        .pdn_q      (pdn_q),
        .pd_inhibit (pd_inhibit),
        .pad_pd_en  (pad_pd_en)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q;

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIR) |=> pad_oe == $past(bus_wdata));

    assert_out_no_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_pd_en) == '0);

    assert_data_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA) |=> pad_out == $past(bus_wdata));

endmodule

// File: tb/gpio_pd_port_tb_top.sv
`timescale 1ns/1ps
module gpio_pd_port_tb_top;

    localparam logic [7:0] A_DATA = 8'h02;
    localparam logic [7:0] A_DIR  = 8'h06;
    localparam logic [7:0] A_PDN  = 8'h10;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } rd_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic       pd_inhibit = 1'b0;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] pad_pd_en;

    int n_checks = 0;
    int n_fail = 0;
    bit rd_d = 1'b0;
    bit done = 1'b0;
    rd_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_pd_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .pad_in     (pad_in),
        .pd_inhibit (pd_inhibit),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_pd_en  (pad_pd_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    always @(posedge clk) rd_d <= bus_rd;

    // scoreboard monitor: read data is valid at the falling edge after the sampled strobe
    always @(negedge clk) begin
        if (rd_d) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R9: unexpected read result 0x%02h expected none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.req, bus_rdata, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        rd_item_t it;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        it.exp = exp; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 pad_oe", pad_oe, 8'h00);
        check("R2 pad_out", pad_out, 8'h00);
        check("R2 pad_pd_en", pad_pd_en, 8'hFF);
        check("R2 rdata", bus_rdata, 8'h00);
        bus_read(A_DIR, 8'h00, "R2 dir read");

        bus_write(A_DIR, 8'hF0);
        check("R1 pad_oe", pad_oe, 8'hF0);
        check("R3 pd off on outputs", pad_pd_en, 8'h0F);
        bus_read(A_DIR, 8'hF0, "R1 dir read");

        bus_write(A_PDN, 8'h01);
        check("R4 low group off, high outputs", pad_pd_en, 8'h00);
        bus_write(A_DIR, 8'h00);
        check("R4 high group on", pad_pd_en, 8'hF0);
        bus_write(A_PDN, 8'h02);
        check("R4 low group on", pad_pd_en, 8'h0F);
        bus_write(A_PDN, 8'h03);
        check("R4 all off", pad_pd_en, 8'h00);
        bus_read(A_PDN, 8'h00, "R5 write-only read");
        bus_write(A_PDN, 8'h00);
        check("R4 all on", pad_pd_en, 8'hFF);
        bus_write(A_DIR, 8'h81);
        check("R3 mixed dir", pad_pd_en, 8'h7E);
        bus_write(A_DIR, 8'h00);

        @(negedge clk);
        pd_inhibit = 1'b1;
        #1;
        check("R6 inhibit", pad_pd_en, 8'h00);
        @(negedge clk);
        pd_inhibit = 1'b0;
        #1;
        check("R6 inhibit released", pad_pd_en, 8'hFF);

        bus_write(A_DATA, 8'hA5);
        check("R7 pad_out while input", pad_out, 8'hA5);
        @(negedge clk);
        pad_in = 8'h3C;
        @(negedge clk);
        @(negedge clk);
        bus_read(A_DATA, 8'h3C, "R8 input readback");
        bus_write(A_DIR, 8'h0F);
        bus_read(A_DATA, 8'h35, "R8 mixed readback");

        @(negedge clk);
        pad_in = 8'hFF;
        bus_addr = A_DATA; bus_rd = 1'b1;
        begin
            rd_item_t it;
            it.exp = 8'h35; it.req = "R8 one-edge pad change hidden";
            sb_q.push_back(it);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        bus_read(A_DATA, 8'hF5, "R8 pad change after two edges");

        bus_write(8'h07, 8'hFF);
        check("R10 pad_oe held", pad_oe, 8'h0F);
        check("R10 pad_out held", pad_out, 8'hA5);
        bus_read(A_DIR, 8'h0F, "R10 dir unchanged");
        bus_read(8'h03, 8'h00, "R9 unmapped read");
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 8'h00);

        bus_write(A_DIR, 8'hFF);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = 8'h11 * (k * 3 + 1);
            bus_write(A_DATA, v);
            check("R7 data pattern", pad_out, v);
            bus_read(A_DATA, v, "R8 output readback");
        end

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9: %0d reads missing expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule